// File: doc/BRIEF.md
# PWM Fine-Edge Validity Gate

This block is a single-channel pulse-width generator built around a time-base counter. Every period it produces a coarse PWM level and, next to it, a fine trim code with a valid flag. An external delay element uses the trim code to place the controlled edge of the pulse with sub-clock precision. The block decides, once per period, whether that trim may be applied. The trim is withheld whenever the controlled edge would fall inside a blanking window at the start of the period. The window is 3 clocks long in normal operation and 6 clocks long while a calibration diagnostic runs.

In up-count mode the falling edge is the controlled edge, so the blanking limits trimming at low duty. In down-count mode the rising edge is the controlled edge, so the limit moves to high duty. The coarse duty always follows the compare value over the full range from 0% to 100%, whether or not trimming is allowed. Period, compare, trim code, count direction and diagnostic mode are captured into shadow registers only at a period boundary, so a change made mid-period takes effect cleanly from the next period.

The time base is a three-state machine. IDLE holds the outputs low and reloads the shadows on every clock. UP counts 0 to P-1. DOWN counts P-1 to 0. Every transition happens at a reload point:
- IDLE→IDLE when the incoming period is 0.
- IDLE/UP/DOWN→UP when the incoming period is non-zero with up-count selected.
- IDLE/UP/DOWN→DOWN when the incoming period is non-zero with down-count selected.
- Any running state→IDLE when a zero period is loaded.

Top module: `pwm_fine_gate`

## Requirements
- R1: While rst_n is low, pwm_out and fine_valid are 0 and fine_code_out is 0. The first rising clock edge after release loads the shadows.
- R2: In up-count mode with shadow period P > 0, the counter steps 0,1,…,P-1 and wraps. pwm_out is 1 exactly while the count is below the shadow compare C, so a window of P clocks holds C high clocks (P when C ≥ P).
- R3: In up-count mode with diagnostics off, fine_valid is 1 for the whole period if and only if 3 ≤ C < P.
- R4: With diagnostics on, the blanking length is 6. In up-count mode fine_valid requires 6 ≤ C < P, and in down-count mode it requires C > 0 and C + 6 ≤ P.
- R5: In down-count mode the counter steps P-1, P-2, …, 0 and wraps. pwm_out is 1 while the count is below C, so the pulse sits at the end of the period and its rising edge is the controlled edge.
- R6: In down-count mode with diagnostics off, fine_valid is 1 if and only if C > 0 and C + 3 ≤ P.
- R7: fine_code_out equals the shadowed trim code while fine_valid is 1, and is 0 while fine_valid is 0.
- R8: Period, compare, trim code, count_down and diag_en are captured only at a reload point: the last count of a period, or every clock in IDLE. Changes at other times do not affect the outputs until the next period.
- R9: A shadow period of 0 holds the block in IDLE with pwm_out 0, fine_valid 0 and fine_code_out 0. A non-zero period loaded there starts counting on the next clock.
- R10: Coarse duty stays exact down to 0% even when trimming is blanked. For example, C = 1 or 2 in up-count mode gives 1 or 2 high clocks per period with fine_valid 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period | input | 16 | Period length in clocks (0 halts) |
| compare | input | 16 | Duty compare value |
| fine_code | input | 8 | Fine edge trim code to forward |
| count_down | input | 1 | 1 selects down-count mode |
| diag_en | input | 1 | 1 selects the 6-clock blanking window |
| pwm_out | output | 1 | Coarse PWM level |
| fine_code_out | output | 8 | Trim code, zero while trimming is blanked |
| fine_valid | output | 1 | Trim may be applied this period |

## Verification
Up-count compares of 0, 2, 3, 10, 20 and 25 around a 20-clock period separate the blanked, just-valid and no-edge cases. The same compares with diagnostics on show whether the 6-clock window replaced the 3-clock one. In down-count mode, compares of 14, 15, 17 and 18 sit on both sides of the high-duty limit for each window length, and 0 confirms that a missing edge is never trimmed. Changing compare and direction mid-period shows whether the shadows load early. A zero period shows whether the machine parks in IDLE, and a 1-clock period tests the shortest legal wrap.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_UP   = 2'd1,
        PH_DOWN = 2'd2
    } phase_e;

endpackage

// File: rtl/ptg_timebase.sv
module ptg_timebase
    import ptg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_in,
    input  logic             down_in,
    input  logic [CNT_W-1:0] sh_period,
    output phase_e           phase,
    output logic [CNT_W-1:0] count,
    output logic             reload
);

    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    phase_e           phase_q, phase_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic             at_end;

    // End-of-period detection per phase
    always_comb begin
        at_end = 1'b1;
        unique case (phase_q)
            PH_IDLE: at_end = 1'b1;
            PH_UP:   at_end = ({1'b0, count_q} + {{CNT_W{1'b0}}, 1'b1})
                              == {1'b0, sh_period};
            PH_DOWN: at_end = (count_q == ZERO);
            default: at_end = 1'b1;
        endcase
    end

    // Next-state and next-count selection
    always_comb begin
        phase_d = phase_q;
        count_d = count_q;
        if (at_end) begin
            if (period_in == ZERO) begin
                phase_d = PH_IDLE;
                count_d = ZERO;
            end else if (down_in) begin
                phase_d = PH_DOWN;
                count_d = period_in - ONE;
            end else begin
                phase_d = PH_UP;
                count_d = ZERO;
            end
        end else begin
            unique case (phase_q)
                PH_UP:   count_d = count_q + ONE;
                PH_DOWN: count_d = count_q - ONE;
                default: count_d = ZERO;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            count_q <= ZERO;
        end else begin
            phase_q <= phase_d;
            count_q <= count_d;
        end
    end

    assign phase  = phase_q;
    assign count  = count_q;
    assign reload = at_end;

endmodule

// File: rtl/ptg_shadow.sv
module ptg_shadow #(
    parameter int CNT_W  = 16,
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload,
    input  logic [CNT_W-1:0]  period_in,
    input  logic [CNT_W-1:0]  compare_in,
    input  logic [CODE_W-1:0] code_in,
    input  logic              down_in,
    input  logic              diag_in,
    output logic [CNT_W-1:0]  sh_period,
    output logic [CNT_W-1:0]  sh_compare,
    output logic [CODE_W-1:0] sh_code,
    output logic              sh_down,
    output logic              sh_diag
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_period  <= '0;
            sh_compare <= '0;
            sh_code    <= '0;
            sh_down    <= 1'b0;
            sh_diag    <= 1'b0;
        end else if (reload) begin
            sh_period  <= period_in;
            sh_compare <= compare_in;
            sh_code    <= code_in;
            sh_down    <= down_in;
            sh_diag    <= diag_in;
        end
    end

endmodule

// File: rtl/ptg_edge_gate.sv
module ptg_edge_gate
    import ptg_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int CODE_W     = 8,
    parameter int BLANK_NORM = 3,
    parameter int BLANK_DIAG = 6
) (
    input  phase_e            phase,
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  sh_period,
    input  logic [CNT_W-1:0]  sh_compare,
    input  logic [CODE_W-1:0] sh_code,
    input  logic              sh_diag,
    output logic              pwm,
    output logic              trim_ok,
    output logic [CODE_W-1:0] trim_code
);

    localparam int          XW     = CNT_W + 1;
    localparam logic [XW-1:0] BL_N = XW'(BLANK_NORM);
    localparam logic [XW-1:0] BL_D = XW'(BLANK_DIAG);

    logic [XW-1:0] blank_len;
    logic [XW-1:0] cmp_x;
    logic [XW-1:0] per_x;
    logic          up_ok;
    logic          dn_ok;

    assign blank_len = sh_diag ? BL_D : BL_N;
    assign cmp_x     = {1'b0, sh_compare};
    assign per_x     = {1'b0, sh_period};

    // Falling edge at offset C must lie past the window and inside the period
    assign up_ok = (cmp_x >= blank_len) && (cmp_x < per_x);
    // Rising edge at offset P-C must lie past the window, and must exist
    assign dn_ok = (cmp_x != '0) && ((cmp_x + blank_len) <= per_x);

    // Output process
    always_comb begin
        pwm       = 1'b0;
        trim_ok   = 1'b0;
        unique case (phase)
            PH_UP: begin
                pwm     = (count < sh_compare);
                trim_ok = up_ok;
            end
            PH_DOWN: begin
                pwm     = (count < sh_compare);
                trim_ok = dn_ok;
            end
            default: begin
                pwm     = 1'b0;
                trim_ok = 1'b0;
            end
        endcase
        trim_code = trim_ok ? sh_code : '0;
    end

endmodule

// File: rtl/pwm_fine_gate.sv
module pwm_fine_gate
    import ptg_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int CODE_W     = 8,
    parameter int BLANK_NORM = 3,
    parameter int BLANK_DIAG = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  period,
    input  logic [CNT_W-1:0]  compare,
    input  logic [CODE_W-1:0] fine_code,
    input  logic              count_down,
    input  logic              diag_en,
    output logic              pwm_out,
    output logic [CODE_W-1:0] fine_code_out,
    output logic              fine_valid
);

    phase_e            phase;
    logic [CNT_W-1:0]  count;
    logic              reload;
    logic [CNT_W-1:0]  sh_period;
    logic [CNT_W-1:0]  sh_compare;
    logic [CODE_W-1:0] sh_code;
    logic              sh_down;
    logic              sh_diag;

    ptg_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .period_in (period),
        .down_in   (count_down),
        .sh_period (sh_period),
        .phase     (phase),
        .count     (count),
        .reload    (reload)
    );

    ptg_shadow #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_sh (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload     (reload),
        .period_in  (period),
        .compare_in (compare),
        .code_in    (fine_code),
        .down_in    (count_down),
        .diag_in    (diag_en),
        .sh_period  (sh_period),
        .sh_compare (sh_compare),
        .sh_code    (sh_code),
        .sh_down    (sh_down),
        .sh_diag    (sh_diag)
    );

    ptg_edge_gate #(
        .CNT_W(CNT_W), .CODE_W(CODE_W),
        .BLANK_NORM(BLANK_NORM), .BLANK_DIAG(BLANK_DIAG)
    ) u_gate (
        .phase      (phase),
        .count      (count),
        .sh_period  (sh_period),
        .sh_compare (sh_compare),
        .sh_code    (sh_code),
        .sh_diag    (sh_diag),
        .pwm        (pwm_out),
        .trim_ok    (fine_valid),
        .trim_code  (fine_code_out)
    );

endmodule

// File: rtl/ptg_checker.sv
module ptg_checker
    import ptg_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int CODE_W     = 8,
    parameter int BLANK_NORM = 3,
    parameter int BLANK_DIAG = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwm_out,
    input logic              fine_valid,
    input logic [CODE_W-1:0] fine_code_out,
    input phase_e            phase,
    input logic [CNT_W-1:0]  count,
    input logic              reload,
    input logic [CNT_W-1:0]  sh_period,
    input logic [CNT_W-1:0]  sh_compare,
    input logic              sh_down,
    input logic              sh_diag
);

    localparam int XW = CNT_W + 1;

    always_comb begin
        if (rst_n == 1'b0) begin
            a_r1_reset_quiet: assert (!pwm_out && !fine_valid && fine_code_out == '0)
                else $error("R1 outputs active in reset");
        end
    end

    a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |-> (count < sh_period));

    a_r3_up_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (fine_valid && !sh_down && !sh_diag) |-> ({1'b0, sh_compare} >= XW'(BLANK_NORM)));

    a_r4_diag_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (fine_valid && !sh_down && sh_diag) |-> ({1'b0, sh_compare} >= XW'(BLANK_DIAG)));

    a_r5_down_step: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DOWN && !reload) |=> (count == $past(count) - CNT_W'(1)));

    a_r6_down_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (fine_valid && sh_down && !sh_diag)
            |-> (({1'b0, sh_compare} + XW'(BLANK_NORM)) <= {1'b0, sh_period}));

    a_r7_code_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (fine_code_out != '0) |-> fine_valid);

    a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |=> ($stable(sh_compare) && $stable(sh_period) && $stable(sh_down)));

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> (!pwm_out && !fine_valid));

endmodule

bind pwm_fine_gate ptg_checker #(
    .CNT_W(CNT_W), .CODE_W(CODE_W),
    .BLANK_NORM(BLANK_NORM), .BLANK_DIAG(BLANK_DIAG)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwm_out       (pwm_out),
    .fine_valid    (fine_valid),
    .fine_code_out (fine_code_out),
    .phase         (phase),
    .count         (count),
    .reload        (reload),
    .sh_period     (sh_period),
    .sh_compare    (sh_compare),
    .sh_down       (sh_down),
    .sh_diag       (sh_diag)
);

// File: tb/tb_pwm_fine_gate.sv
module tb_pwm_fine_gate;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] period;
    logic [15:0] compare;
    logic [7:0]  fine_code;
    logic        count_down;
    logic        diag_en;
    logic        pwm_out;
    logic [7:0]  fine_code_out;
    logic        fine_valid;

    always #4 clk = ~clk;

    pwm_fine_gate dut (
        .clk(clk), .rst_n(rst_n), .period(period), .compare(compare),
        .fine_code(fine_code), .count_down(count_down), .diag_en(diag_en),
        .pwm_out(pwm_out), .fine_code_out(fine_code_out), .fine_valid(fine_valid)
    );

    int n_vec = 0;
    int n_bad = 0;

    // Reference model state, derived from the requirements
    int m_run = 0;   // 0 idle, 1 up, 2 down
    int m_cnt = 0;
    int m_p = 0, m_c = 0, m_code = 0;
    bit m_dn = 0, m_dg = 0;
    bit m_bnd;
    int m_bl;
    bit e_pwm, e_val;
    int e_code;
    string e_tag;

    bit    q_pwm[$];
    bit    q_val[$];
    int    q_code[$];
    string q_tag[$];

    // Driver side of the scoreboard: predict each cycle and queue it
    always @(posedge clk) begin
        if (rst_n === 1'b1) begin
            m_bnd = (m_run == 0) || (m_run == 1 && m_cnt == m_p - 1) || (m_run == 2 && m_cnt == 0);
            if (m_bnd) begin   // R8 reload point
                m_p = int'(period); m_c = int'(compare); m_code = int'(fine_code);
                m_dn = count_down; m_dg = diag_en;
                if (m_p == 0) begin m_run = 0; m_cnt = 0; end
                else if (m_dn) begin m_run = 2; m_cnt = m_p - 1; end
                else begin m_run = 1; m_cnt = 0; end
            end else if (m_run == 1) m_cnt = m_cnt + 1;
            else m_cnt = m_cnt - 1;

            m_bl = m_dg ? 6 : 3;
            if (m_run == 0) begin
                e_pwm = 0; e_val = 0; e_tag = "R9";
            end else if (m_run == 1) begin
                e_pwm = (m_cnt < m_c);
                e_val = (m_c >= m_bl) && (m_c < m_p);
                e_tag = m_dg ? "R2/R4/R10" : "R2/R3/R10";
            end else begin
                e_pwm = (m_cnt < m_c);
                e_val = (m_c > 0) && (m_c + m_bl <= m_p);
                e_tag = m_dg ? "R5/R4" : "R5/R6";
            end
            e_code = e_val ? m_code : 0;
            if (int'(compare) != m_c || count_down != m_dn || int'(period) != m_p)
                e_tag = {e_tag, "/R7/R8"};
            else
                e_tag = {e_tag, "/R7"};
            q_pwm.push_back(e_pwm);
            q_val.push_back(e_val);
            q_code.push_back(e_code);
            q_tag.push_back(e_tag);
        end
    end

    // Monitor side: compare away from the active edge
    always @(negedge clk) begin
        if (q_pwm.size() > 0) begin
            bit    xp, xv;
            int    xc;
            string xt;
            xp = q_pwm.pop_front();
            xv = q_val.pop_front();
            xc = q_code.pop_front();
            xt = q_tag.pop_front();
            n_vec++;
            if (pwm_out !== xp || fine_valid !== xv || int'(fine_code_out) != xc) begin
                n_bad++;
                $display("FAIL %s: pwm=%0b valid=%0b code=%0h expected pwm=%0b valid=%0b code=%0h",
                         xt, pwm_out, fine_valid, fine_code_out, xp, xv, xc);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setcfg(input int p, input int c, input int code, input bit dn, input bit dg);
        @(negedge clk);
        period = 16'(p); compare = 16'(c); fine_code = 8'(code);
        count_down = dn; diag_en = dg;
    endtask

    // Count high pwm clocks and valid clocks over a window of n clocks
    task automatic window(input int n, output int hi, output int vl);
        hi = 0; vl = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out === 1'b1) hi++;
            if (fine_valid === 1'b1) vl++;
        end
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int hi, vl;
        rst_n = 1'b0;
        period = 16'd20; compare = 16'd10; fine_code = 8'h5A;
        count_down = 1'b0; diag_en = 1'b0;
        hold(3);
        chk("R1 pwm_out in reset", int'(pwm_out), 0);
        chk("R1 fine_valid in reset", int'(fine_valid), 0);
        chk("R1 fine_code_out in reset", int'(fine_code_out), 0);
        @(negedge clk) rst_n = 1'b1;
        hold(60);

        // Up-count around the 3-clock window (R2, R3, R10)
        setcfg(20, 2, 8'h33, 0, 0);  hold(45);
        window(20, hi, vl);
        chk("R10 high clocks at C=2", hi, 2);
        chk("R10 valid clocks at C=2", vl, 0);
        setcfg(20, 1, 8'h33, 0, 0);  hold(45);
        window(20, hi, vl);
        chk("R10 high clocks at C=1", hi, 1);
        setcfg(20, 3, 8'h44, 0, 0);  hold(45);
        window(20, hi, vl);
        chk("R3 valid clocks at C=3", vl, 20);
        setcfg(20, 0, 8'h11, 0, 0);  hold(45);
        window(20, hi, vl);
        chk("R2 high clocks at C=0", hi, 0);
        setcfg(20, 25, 8'h22, 0, 0); hold(45);
        window(20, hi, vl);
        chk("R2 high clocks at C>P", hi, 20);
        chk("R3 valid clocks at C>P", vl, 0);
        setcfg(20, 20, 8'h22, 0, 0); hold(45);

        // Diagnostic window (R4)
        setcfg(20, 5, 8'h66, 0, 1);  hold(45);
        window(20, hi, vl);
        chk("R4 valid clocks up C=5", vl, 0);
        setcfg(20, 6, 8'h66, 0, 1);  hold(45);

        // Down-count (R5, R6, R4)
        setcfg(20, 17, 8'h77, 1, 0); hold(45);
        window(20, hi, vl);
        chk("R5 high clocks down C=17", hi, 17);
        chk("R6 valid clocks down C=17", vl, 20);
        setcfg(20, 18, 8'h77, 1, 0); hold(45);
        window(20, hi, vl);
        chk("R6 valid clocks down C=18", vl, 0);
        setcfg(20, 14, 8'h88, 1, 1); hold(45);
        setcfg(20, 15, 8'h88, 1, 1); hold(45);
        setcfg(20, 0, 8'h99, 1, 0);  hold(45);
        setcfg(20, 2, 8'h99, 1, 0);  hold(45);
        window(20, hi, vl);
        chk("R5 high clocks down C=2", hi, 2);

        // Mid-period changes (R8)
        setcfg(20, 10, 8'hA5, 0, 0); hold(47);
        compare = 16'd4;  hold(3);
        count_down = 1'b1; hold(5);
        compare = 16'd12; diag_en = 1'b1; hold(45);

        // Zero period and shortest period (R9)
        setcfg(0, 5, 8'hC3, 0, 0);   hold(30);
        chk("R9 pwm_out at zero period", int'(pwm_out), 0);
        chk("R9 fine_valid at zero period", int'(fine_valid), 0);
        setcfg(1, 1, 8'hC3, 0, 0);   hold(10);
        chk("R9 pwm_out after restart P=1", int'(pwm_out), 1);
        setcfg(0, 0, 8'h00, 1, 0);   hold(10);

        hold(3);
        summary();
        $finish;
    end

endmodule